// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Unit

This block sits in the instruction-decode stage of a five-stage pipeline. While an instruction is decoded, the block looks at the three stages further down the pipe (execute, memory access and write-back). From each stage it takes the destination register index, the register-write flag and the value that stage will write. It compares those indices against the two source register indices of the decoded instruction. For each operand it then picks either the register-file read data or the newest value still in flight. The chosen values are captured into the A and B operand registers that feed the execute stage.

Each operand reports a 2-bit source code alongside its value. A value produced in execute can therefore reach the very next instruction's execute inputs. A load still sitting in execute has no data yet, so it is never a forwarding source. That hazard is left to the separate stall logic.

Top module: `opnd_fwd_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, both operand registers hold zero and both select codes hold 00.
- R2: When no later stage matches a source index, the operand register takes the register-file read data, and the select code is 00.
- R3: A match against the execute stage loads the execute result, and the select code is 01.
- R4: A match against the memory-access stage loads its result, and the select code is 10.
- R5: A match against the write-back stage loads its result, and the select code is 11.
- R6: When several stages match, the youngest producer wins. Execute beats memory access, and memory access beats write-back.
- R7: A source index of 0 never matches any stage, even when a stage writes register 0. The operand then takes the register-file data with code 00.
- R8: A stage whose write flag is low never matches.
- R9: When `exe_load` is high, the execute stage never matches. Selection then falls through to memory access, write-back or the register file, in that order.
- R10: Operand A and operand B are resolved independently of each other, and both may use the same stage.
- R11: Operand values and select codes change only on a rising clock edge. Each edge takes the inputs present just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_idx | input | REG_AW | Source register index for operand A |
| src_b_idx | input | REG_AW | Source register index for operand B |
| rf_a_data | input | DATA_W | Register-file read data for A |
| rf_b_data | input | DATA_W | Register-file read data for B |
| exe_dst | input | REG_AW | Destination index in execute |
| exe_we | input | 1 | Execute stage will write a register |
| exe_load | input | 1 | Instruction in execute is a load |
| exe_res | input | DATA_W | Execute result |
| dm_dst | input | REG_AW | Destination index in memory access |
| dm_we | input | 1 | Memory-access stage will write a register |
| dm_res | input | DATA_W | Memory-access result (load data or passed ALU value) |
| wb_dst | input | REG_AW | Destination index in write-back |
| wb_we | input | 1 | Write-back stage will write a register |
| wb_res | input | DATA_W | Write-back value |
| opa_q | output | DATA_W | Registered operand A |
| opb_q | output | DATA_W | Registered operand B |
| opa_sel | output | 2 | Source code of A: 00 register file, 01 execute, 10 memory access, 11 write-back |
| opb_sel | output | 2 | Source code of B, same encoding |

## Verification
Some rules are checked by the assertions on every clock: a register-0 source always yields code 00, and a load in execute never yields code 01. They also check that an execute, memory-access or write-back hit places that stage's value in the operand register one edge later, and that no hit leaves the register-file data there. The bench scenarios show the rest. Only they can exercise the priority ordering when all three stages hold the same index, and the fall-through when a load in execute masks the youngest producer. They also cover independent A/B resolution, the reset values, and the fact that outputs stay fixed between clock edges.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NSTG = 3;  // execute, memory access, write-back (youngest first)

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EXE = 2'b01,
    SEL_DM  = 2'b10,
    SEL_WB  = 2'b11
  } src_sel_e;

  // Youngest producer wins: bit 0 (execute) beats bit 1, bit 1 beats bit 2 (R6)
  function automatic src_sel_e pick_sel(input logic [NSTG-1:0] hit);
    if (hit[0])      return SEL_EXE;
    else if (hit[1]) return SEL_DM;
    else if (hit[2]) return SEL_WB;
    else             return SEL_RF;
  endfunction
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [REG_AW-1:0] dst_idx,
  input  logic              wr_en,
  output logic              hit
);
  // register 0 is hardwired, a silent stage never produces (R7, R8)
  always_comb hit = wr_en && (dst_idx != '0) && (dst_idx == src_idx);
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0]            src_idx,
  input  logic [DATA_W-1:0]            rf_data,
  input  logic [NSTG-1:0][REG_AW-1:0]  stg_dst,
  input  logic [NSTG-1:0]              stg_we,
  input  logic [NSTG-1:0][DATA_W-1:0]  stg_val,
  output logic [NSTG-1:0]              hit,
  output src_sel_e                     sel,
  output logic [DATA_W-1:0]            value
);
  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    fwd_match #(.REG_AW(REG_AW)) u_match (
      .src_idx (src_idx),
      .dst_idx (stg_dst[s]),
      .wr_en   (stg_we[s]),
      .hit     (hit[s])
    );
  end

  always_comb begin
    sel = pick_sel(hit);
    unique case (sel)
      SEL_EXE: value = stg_val[0];
      SEL_DM:  value = stg_val[1];
      SEL_WB:  value = stg_val[2];
      default: value = rf_data;
    endcase
  end
endmodule

// File: rtl/opnd_fwd_unit.sv
module opnd_fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src_a_idx,
  input  logic [REG_AW-1:0] src_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [REG_AW-1:0] exe_dst,
  input  logic              exe_we,
  input  logic              exe_load,
  input  logic [DATA_W-1:0] exe_res,
  input  logic [REG_AW-1:0] dm_dst,
  input  logic              dm_we,
  input  logic [DATA_W-1:0] dm_res,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_we,
  input  logic [DATA_W-1:0] wb_res,
  output logic [DATA_W-1:0] opa_q,
  output logic [DATA_W-1:0] opb_q,
  output logic [1:0]        opa_sel,
  output logic [1:0]        opb_sel
);
  localparam int NOPS = 2;

  logic [NSTG-1:0][REG_AW-1:0] stg_dst;
  logic [NSTG-1:0]             stg_we;
  logic [NSTG-1:0][DATA_W-1:0] stg_val;

  // A load in execute has no data yet: it is not a producer there (R9)
  always_comb begin
    stg_dst = {wb_dst, dm_dst, exe_dst};
    stg_we  = {wb_we, dm_we, exe_we && !exe_load};
    stg_val = {wb_res, dm_res, exe_res};
  end

  logic [NOPS-1:0][REG_AW-1:0] src_idx;
  logic [NOPS-1:0][DATA_W-1:0] rf_data;
  logic [NOPS-1:0][NSTG-1:0]   op_hit;
  src_sel_e                    op_sel [NOPS];
  logic [NOPS-1:0][DATA_W-1:0] op_val;

  always_comb begin
    src_idx = {src_b_idx, src_a_idx};
    rf_data = {rf_b_data, rf_a_data};
  end

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    fwd_operand #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_op (
      .src_idx (src_idx[o]),
      .rf_data (rf_data[o]),
      .stg_dst (stg_dst),
      .stg_we  (stg_we),
      .stg_val (stg_val),
      .hit     (op_hit[o]),
      .sel     (op_sel[o]),
      .value   (op_val[o])
    );
  end

  // named events for the checker
  logic [NSTG-1:0] hit_a, hit_b;
  always_comb begin
    hit_a = op_hit[0];
    hit_b = op_hit[1];
  end

  // ID/EXE operand latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q   <= '0;
      opb_q   <= '0;
      opa_sel <= SEL_RF;
      opb_sel <= SEL_RF;
    end else begin
      opa_q   <= op_val[0];
      opb_q   <= op_val[1];
      opa_sel <= op_sel[0];
      opb_sel <= op_sel[1];
    end
  end
endmodule

// File: rtl/fwd_chk.sv
module fwd_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] src_a_idx,
  input logic [REG_AW-1:0] src_b_idx,
  input logic [DATA_W-1:0] rf_a_data,
  input logic              exe_load,
  input logic [DATA_W-1:0] exe_res,
  input logic [DATA_W-1:0] dm_res,
  input logic [DATA_W-1:0] wb_res,
  input logic [2:0]        hit_a,
  input logic [2:0]        hit_b,
  input logic [DATA_W-1:0] opa_q,
  input logic [1:0]        opa_sel,
  input logic [1:0]        opb_sel
);
  assert_no_hit_rf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a == 3'b000) |=> (opa_sel == 2'b00 && opa_q == $past(rf_a_data)));

  assert_exe_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a[0] |=> (opa_sel == 2'b01 && opa_q == $past(exe_res)));

  assert_dm_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a == 3'b010 || hit_a == 3'b110) |=> (opa_q == $past(dm_res)));

  assert_wb_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a == 3'b100) |=> (opa_q == $past(wb_res)));

  assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_idx == '0) |=> (opa_sel == 2'b00));

  assert_zero_src_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_idx == '0) |=> (opb_sel == 2'b00));

  assert_load_no_exe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exe_load |=> (opa_sel != 2'b01 && opb_sel != 2'b01));

  assert_b_exe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b[0] |=> (opb_sel == 2'b01));
endmodule

bind opnd_fwd_unit fwd_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_fwd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_a_idx (src_a_idx),
  .src_b_idx (src_b_idx),
  .rf_a_data (rf_a_data),
  .exe_load  (exe_load),
  .exe_res   (exe_res),
  .dm_res    (dm_res),
  .wb_res    (wb_res),
  .hit_a     (hit_a),
  .hit_b     (hit_b),
  .opa_q     (opa_q),
  .opa_sel   (opa_sel),
  .opb_sel   (opb_sel)
);

// File: tb/test_opnd_fwd_unit.sv
module test_opnd_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [DW-1:0] RFA = 32'h1111_1111, RFB = 32'h2222_2222;
  localparam logic [DW-1:0] EXV = 32'h3333_3333, DMV = 32'h4444_4444, WBV = 32'h5555_5555;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] src_a_idx = '0, src_b_idx = '0, exe_dst = '0, dm_dst = '0, wb_dst = '0;
  logic [DW-1:0] rf_a_data = RFA, rf_b_data = RFB, exe_res = EXV, dm_res = DMV, wb_res = WBV;
  logic exe_we = 0, exe_load = 0, dm_we = 0, wb_we = 0;
  logic [DW-1:0] opa_q, opb_q;
  logic [1:0] opa_sel, opb_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_fwd_unit #(.DATA_W(DW), .REG_AW(AW)) i_opnd_fwd_unit (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [4:0] sa, sb, ed; logic ew, el;
    logic [4:0] dd; logic dw; logic [4:0] wd; logic ww;
    logic [1:0] xa, xb; logic [3:0] rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd1,  5'd2,  5'd1,  1'b0, 1'b0, 5'd2,  1'b0, 5'd1,  1'b0, 2'd0, 2'd0, 4'd2},  // R2 no writers
    '{5'd3,  5'd4,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'd1, 2'd0, 4'd3},  // R3 execute hit
    '{5'd5,  5'd5,  5'd0,  1'b0, 1'b0, 5'd5,  1'b1, 5'd0,  1'b0, 2'd2, 2'd2, 4'd4},  // R4 memory hit both
    '{5'd7,  5'd8,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd7,  1'b1, 2'd3, 2'd0, 4'd5},  // R5 write-back hit
    '{5'd9,  5'd9,  5'd9,  1'b1, 1'b0, 5'd9,  1'b1, 5'd9,  1'b1, 2'd1, 2'd1, 4'd6},  // R6 all three match
    '{5'd6,  5'd1,  5'd0,  1'b0, 1'b0, 5'd6,  1'b1, 5'd6,  1'b1, 2'd2, 2'd0, 4'd6},  // R6 memory over wb
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0, 4'd7},  // R7 register 0
    '{5'd10, 5'd11, 5'd10, 1'b0, 1'b0, 5'd10, 1'b0, 5'd10, 1'b1, 2'd3, 2'd0, 4'd8},  // R8 disabled writers
    '{5'd12, 5'd12, 5'd12, 1'b1, 1'b1, 5'd12, 1'b1, 5'd0,  1'b0, 2'd2, 2'd2, 4'd9},  // R9 load falls to memory
    '{5'd13, 5'd14, 5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 4'd9},  // R9 load falls to rf
    '{5'd16, 5'd15, 5'd15, 1'b1, 1'b0, 5'd0,  1'b0, 5'd16, 1'b1, 2'd3, 2'd1, 4'd10}  // R10 independent
  };

  function automatic logic [DW-1:0] src_value(input logic [1:0] code, input logic [DW-1:0] rf);
    case (code)
      2'd1:    return EXV;
      2'd2:    return DMV;
      2'd3:    return WBV;
      default: return rf;
    endcase
  endfunction

  task automatic check(input string rq, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "opa_q", opa_q, '0);
    check("R1", "opb_q", opb_q, '0);
    check("R1", "sel", {30'd0, opa_sel}, 32'd0);
    rst_n = 1;

    foreach (VECS[i]) begin
      string rq;
      @(negedge clk);
      src_a_idx = VECS[i].sa; src_b_idx = VECS[i].sb;
      exe_dst = VECS[i].ed; exe_we = VECS[i].ew; exe_load = VECS[i].el;
      dm_dst = VECS[i].dd; dm_we = VECS[i].dw;
      wb_dst = VECS[i].wd; wb_we = VECS[i].ww;
      @(negedge clk);
      rq = $sformatf("R%0d", VECS[i].rq);
      check(rq, "opa_sel", {30'd0, opa_sel}, {30'd0, VECS[i].xa});
      check(rq, "opb_sel", {30'd0, opb_sel}, {30'd0, VECS[i].xb});
      check(rq, "opa_q", opa_q, src_value(VECS[i].xa, RFA));
      check(rq, "opb_q", opb_q, src_value(VECS[i].xb, RFB));
    end

    // R11: new inputs do not show before the next rising edge
    @(negedge clk);
    src_a_idx = 5'd20; exe_dst = 5'd20; exe_we = 1; exe_load = 0;
    src_b_idx = 5'd21; dm_we = 0; wb_we = 0;
    #1;
    check("R11", "opa_q held", opa_q, src_value(2'd3, RFA));
    check("R11", "opb_sel held", {30'd0, opb_sel}, 32'd1);
    @(negedge clk);
    check("R11", "opa_q after edge", opa_q, EXV);
    check("R11", "opb_q after edge", opb_q, RFB);

    // R1: reset mid-run clears the latch
    rst_n = 0;
    @(negedge clk);
    check("R1", "opa_q in reset", opa_q, '0);
    check("R1", "opa_sel in reset", {30'd0, opa_sel}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R3", "opa_sel after reset", {30'd0, opa_sel}, 32'd1);

    finish_run();
  end
endmodule